// File: doc/BRIEF.md
# Page Write Buffer and Commit Engine

This block sits between a serial memory client and a non-volatile array. After the client decodes a write command, it passes the starting word address and then one strobe per received data byte. The block holds those bytes in a page-sized latch and writes none of them to the array until the client signals the end of the transaction. At that point a self-timed write cycle starts. The loaded bytes leave through the array write port, one per clock. The block then holds its busy flag until a programmable number of clocks has passed since the commit.

The in-page offset advances with each byte and wraps inside the current aligned page. It never carries into the page number. When more bytes arrive than the page holds, later bytes replace earlier ones. A write-protect input blocks writes to the upper half of the address space. That input is sampled once, when the commit is accepted. A commit with no buffered data, such as an address-only dummy write, does not start a write cycle.

Top module: `page_commit_engine`

## Requirements
- R1: A load strobe sets the page number (address bits above the low 4) and the in-page offset (low 4 bits). Each accepted byte goes into the slot at the current offset, and the offset then advances modulo 16. The page number never changes, so a write past offset 15 continues at offset 0 of the same page.
- R2: When more than 16 bytes arrive before the commit, each later byte replaces the byte held in its slot. Only the most recent byte per slot is written.
- R3: No array write occurs before a commit strobe is accepted. A commit is accepted when the block is idle and at least one byte has been loaded since the last load strobe.
- R4: Only slots that were loaded are written. The writes come in ascending slot order on consecutive clocks, starting in the clock after the commit is accepted, with address {page, slot}.
- R5: When write-protect is high at commit and address bit 9 of the page is 1 (0x200–0x3FF), no array write occurs. Busy still runs for the full cycle. Pages with bit 9 equal to 0 are written regardless of write-protect.
- R6: Write-protect is sampled only in the clock the commit is accepted. Changes during the write cycle have no effect.
- R7: Busy rises in the clock after an accepted commit and stays high for exactly WR_CYCLES clocks.
- R8: A commit strobe with no byte loaded since the last load strobe starts no cycle: busy stays low and nothing is written.
- R9: While busy is high, load strobes, byte strobes and commit strobes are ignored. This includes the offset, the page and the buffered contents.
- R10: After reset, busy and the write enable are low and the buffer is empty, so a commit does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_addr | input | 1 | Load the start address for a new transaction |
| start_addr | input | ADDR_W | Start word address (page and offset) |
| byte_vld | input | 1 | One received data byte is present |
| byte_data | input | DATA_W | Received data byte |
| stop_i | input | 1 | End of transaction; commit request |
| wp_i | input | 1 | Write-protect for the upper half of the array |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
A wrong valid mask shows up directly on the write port. Extra, missing or out-of-order writes appear within the first 16 clocks after a commit, and an empty mask turns a real commit into a silent no-op. A corrupted offset or page misplaces data in the first write, and a write landing outside the loaded page is visible at once. A miscounted delay counter shows only when busy falls, WR_CYCLES clocks after the commit. A protect sample taken at the wrong time shows as writes into the upper half during that same cycle.

// File: rtl/pwb_pkg.sv
// Shared types for the page write buffer and commit engine.
package pwb_pkg;

    // Commit sequencer phases: idle, draining loaded slots, waiting out the cycle.
    typedef enum logic [1:0] {
        CS_IDLE   = 2'd0,
        CS_WRITE  = 2'd1,
        CS_SETTLE = 2'd2
    } commit_state_t;

endpackage

// File: rtl/pwb_page_latch.sv
// Page latch: one data register and one loaded flag per slot.
// Assumes clr_mask and wr_en are never asserted together by the parent;
// clr_mask wins if they are. Data registers are not reset; the loaded
// flags decide which slots mean anything.
module pwb_page_latch #(
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_mask,
    input  logic                  wr_en,
    input  logic [OFF_W-1:0]      wr_off,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [OFF_W-1:0]      rd_off,
    output logic [DATA_W-1:0]     rd_data,
    output logic [PAGE_BYTES-1:0] mask
);

    logic [PAGE_BYTES*DATA_W-1:0] flat;

    // Per-slot data storage; a later byte to the same slot replaces the earlier one.
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (wr_en && (wr_off == OFF_W'(g)))
                slot_q <= wr_data;
        end
        assign flat[g*DATA_W +: DATA_W] = slot_q;
    end

    // Loaded flags: set on write, cleared on new transaction or on commit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask <= '0;
        else if (clr_mask)
            mask <= '0;
        else if (wr_en)
            mask <= mask | (PAGE_BYTES'(1) << wr_off);
    end

    assign rd_data = flat[rd_off*DATA_W +: DATA_W];

endmodule

// File: rtl/pwb_slot_picker.sv
// Lowest-set-bit finder over the pending-slot vector.
// Purely combinational; assumes nothing about the input.
module pwb_slot_picker #(
    parameter int PAGE_BYTES = 16,
    localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
    input  logic [PAGE_BYTES-1:0] pend,
    output logic [OFF_W-1:0]      idx,
    output logic                  any
);

    // Scan from the top down so the lowest pending slot wins.
    always_comb begin
        idx = '0;
        for (int i = PAGE_BYTES - 1; i >= 0; i--) begin
            if (pend[i])
                idx = OFF_W'(i);
        end
    end

    assign any = |pend;

endmodule

// File: rtl/pwb_commit_seq.sv
// Commit sequencer: on start, loads the pending-slot vector and the cycle
// counter. It issues one array write per clock for the lowest pending slot,
// then idles until WR_CYCLES clocks have elapsed.
// Assumes WR_CYCLES > PAGE_BYTES, so every pending slot drains before the
// counter expires.
module pwb_commit_seq
    import pwb_pkg::*;
#(
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 625000,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int CNT_W     = $clog2(WR_CYCLES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [PAGE_BYTES-1:0] init_mask,
    input  logic [OFF_W-1:0]      pick_idx,
    input  logic                  pick_any,
    output logic [PAGE_BYTES-1:0] pend,
    output logic                  mem_we,
    output logic                  busy
);

    commit_state_t     state;
    logic [CNT_W-1:0]  cnt;
    logic [PAGE_BYTES-1:0] pend_next;

    assign pend_next = pend & ~(PAGE_BYTES'(1) << pick_idx);

    // Phase and cycle-counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CS_IDLE;
            pend  <= '0;
            cnt   <= '0;
        end else begin
            case (state)
                CS_IDLE: begin
                    if (start) begin
                        pend  <= init_mask;
                        cnt   <= CNT_W'(WR_CYCLES - 1);
                        state <= (|init_mask) ? CS_WRITE : CS_SETTLE;
                    end
                end
                CS_WRITE: begin
                    pend <= pend_next;
                    cnt  <= cnt - 1'b1;
                    if (cnt == '0) begin
                        pend  <= '0;
                        state <= CS_IDLE;
                    end else if (pend_next == '0) begin
                        state <= CS_SETTLE;
                    end
                end
                CS_SETTLE: begin
                    if (cnt == '0)
                        state <= CS_IDLE;
                    else
                        cnt <= cnt - 1'b1;
                end
                default: state <= CS_IDLE;
            endcase
        end
    end

    assign mem_we = (state == CS_WRITE) && pick_any;
    assign busy   = (state != CS_IDLE);

endmodule

// File: rtl/page_commit_engine.sv
// Page write buffer and commit engine.
// Collects data bytes into a page latch at an offset that wraps inside the
// aligned page. On an accepted commit it applies upper-half write protection
// (sampled once) and drains the loaded slots to the array write port.
// Assumes the client never raises load_addr, byte_vld and stop_i in the same
// clock. All three are ignored while busy.
module page_commit_engine #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 625000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_addr,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              busy
);

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic [PAGE_W-1:0]     page_q;
    logic [OFF_W-1:0]      off_q;
    logic [PAGE_BYTES-1:0] mask;
    logic [PAGE_BYTES-1:0] pend;
    logic [PAGE_BYTES-1:0] init_mask;
    logic [OFF_W-1:0]      pick_idx;
    logic                  pick_any;
    logic                  acc_load;
    logic                  acc_byte;
    logic                  acc_stop;
    logic                  upper_prot;

    assign acc_load   = load_addr && !busy;
    assign acc_byte   = byte_vld && !busy && !load_addr;
    assign acc_stop   = stop_i && !busy && (|mask);
    assign upper_prot = wp_i && page_q[PAGE_W-1];
    assign init_mask  = upper_prot ? '0 : mask;

    // Address pointer: page fixed per transaction, offset wraps in the page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            off_q  <= '0;
        end else if (acc_load) begin
            page_q <= start_addr[ADDR_W-1:OFF_W];
            off_q  <= start_addr[OFF_W-1:0];
        end else if (acc_byte) begin
            off_q  <= off_q + 1'b1;
        end
    end

    pwb_page_latch #(
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_mask (acc_load || acc_stop),
        .wr_en    (acc_byte),
        .wr_off   (off_q),
        .wr_data  (byte_data),
        .rd_off   (pick_idx),
        .rd_data  (mem_wdata),
        .mask     (mask)
    );

    pwb_slot_picker #(
        .PAGE_BYTES (PAGE_BYTES)
    ) u_pick (
        .pend (pend),
        .idx  (pick_idx),
        .any  (pick_any)
    );

    pwb_commit_seq #(
        .PAGE_BYTES (PAGE_BYTES),
        .WR_CYCLES  (WR_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (acc_stop),
        .init_mask (init_mask),
        .pick_idx  (pick_idx),
        .pick_any  (pick_any),
        .pend      (pend),
        .mem_we    (mem_we),
        .busy      (busy)
    );

    assign mem_addr = {page_q, pick_idx};

endmodule

// File: rtl/pwb_checker.sv
// Port-level protocol checker for page_commit_engine, attached by bind.
// Keeps its own view of the page, the protect sample and the busy length.
module pwb_checker #(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 625000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_addr,
    input logic [ADDR_W-1:0] start_addr,
    input logic              byte_vld,
    input logic              stop_i,
    input logic              wp_i,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy
);

    localparam int OFF_W = $clog2(PAGE_BYTES);

    logic [ADDR_W-OFF_W-1:0] exp_page;
    logic                    got_byte;
    logic                    wp_seen;
    int unsigned             busy_len;

    // Track the transaction page, loaded-data flag and protect sample from the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_page <= '0;
            got_byte <= 1'b0;
            wp_seen  <= 1'b0;
            busy_len <= 0;
        end else begin
            busy_len <= busy ? busy_len + 1 : 0;
            if (!busy) begin
                if (load_addr) begin
                    exp_page <= start_addr[ADDR_W-1:OFF_W];
                    got_byte <= 1'b0;
                end else if (byte_vld) begin
                    got_byte <= 1'b1;
                end else if (stop_i && got_byte) begin
                    got_byte <= 1'b0;
                    wp_seen  <= wp_i;
                end
            end
        end
    end

    // R1: every write stays inside the page set by the last load.
    a_r1_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[ADDR_W-1:OFF_W] == exp_page));

    // R3: nothing reaches the array outside a write cycle.
    a_r3_no_early_write: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);

    // R5: with protect sampled high, no write lands in the upper half.
    a_r5_upper_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wp_seen) |-> !mem_addr[ADDR_W-1]);

    // R7: busy lasts exactly WR_CYCLES clocks.
    a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == WR_CYCLES));

    // R8: a commit with nothing loaded starts no cycle.
    a_r8_empty_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !busy && !load_addr && !byte_vld && !got_byte) |=> !busy);

endmodule

bind page_commit_engine pwb_checker #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES),
    .WR_CYCLES  (WR_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_addr  (load_addr),
    .start_addr (start_addr),
    .byte_vld   (byte_vld),
    .stop_i     (stop_i),
    .wp_i       (wp_i),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .busy       (busy)
);

// File: tb/page_commit_engine_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module page_commit_engine_tb;

    localparam int WRC = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_addr = 1'b0;
    logic [9:0] start_addr = '0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic       stop_i = 1'b0;
    logic       wp_i = 1'b0;
    logic       mem_we;
    logic [9:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       busy;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int log_n = 0;
    int c0 = 0;
    logic [9:0] log_addr [32];
    logic [7:0] log_data [32];
    int         log_cyc  [32];

    always #4 clk = ~clk;   // 125 MHz

    page_commit_engine #(.WR_CYCLES(WRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_addr(load_addr), .start_addr(start_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .stop_i(stop_i), .wp_i(wp_i),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Record array writes away from the clock edge.
    always @(negedge clk) begin
        if (mem_we) begin
            if (log_n < 32) begin
                log_addr[log_n] = mem_addr;
                log_data[log_n] = mem_wdata;
                log_cyc[log_n]  = cyc;
            end
            log_n = log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [9:0] a);
        @(negedge clk); load_addr = 1'b1; start_addr = a;
        @(negedge clk); load_addr = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        @(negedge clk); byte_vld = 1'b1; byte_data = d;
        @(negedge clk); byte_vld = 1'b0;
    endtask

    // Commit and wait for busy to drop; mode 1 raises protect, mode 2 pokes inputs.
    task automatic commit(input int mode, output int blen);
        @(negedge clk); stop_i = 1'b1; c0 = cyc;
        @(negedge clk); stop_i = 1'b0;
        blen = 0;
        while (busy && blen < 10 * WRC) begin
            blen++;
            if (mode == 1) wp_i = 1'b1;
            if (mode == 2 && blen == 3) begin
                load_addr = 1'b1; start_addr = 10'h090; byte_vld = 1'b1;
                byte_data = 8'hEE; stop_i = 1'b1;
            end
            if (mode == 2 && blen == 4) begin
                load_addr = 1'b0; byte_vld = 1'b0; stop_i = 1'b0;
            end
            @(negedge clk);
        end
    endtask

    task automatic exp_write(input int i, input logic [9:0] a, input logic [7:0] d, input string req);
        check(log_addr[i] == a, req, log_addr[i], a);
        check(log_data[i] == d, req, log_data[i], d);
        check(log_cyc[i] == c0 + 1 + i, {req, " cycle"}, log_cyc[i], c0 + 1 + i);
    endtask

    task automatic t_reset();
        int bl;
        check(busy == 1'b0, "R10 busy", busy, 0);
        check(mem_we == 1'b0, "R10 mem_we", mem_we, 0);
        log_n = 0;
        commit(0, bl);
        check(bl == 0, "R10 commit after reset", bl, 0);
        check(log_n == 0, "R10 writes", log_n, 0);
    endtask

    task automatic t_single();
        int bl;
        log_n = 0;
        load(10'h123); send(8'hA5);
        repeat (3) @(negedge clk);
        check(log_n == 0, "R3 write before commit", log_n, 0);
        commit(0, bl);
        check(bl == WRC, "R7 busy length", bl, WRC);
        check(log_n == 1, "R3 write count", log_n, 1);
        exp_write(0, 10'h123, 8'hA5, "R3 single byte");
    endtask

    task automatic t_wrap();
        int bl;
        log_n = 0;
        load(10'h0FD);
        for (int i = 0; i < 5; i++) send(8'h11 + 8'(i));
        commit(0, bl);
        check(log_n == 5, "R4 write count", log_n, 5);
        exp_write(0, 10'h0F0, 8'h14, "R1 wrap slot0");
        exp_write(1, 10'h0F1, 8'h15, "R1 wrap slot1");
        exp_write(2, 10'h0FD, 8'h11, "R4 order slotD");
        exp_write(3, 10'h0FE, 8'h12, "R4 order slotE");
        exp_write(4, 10'h0FF, 8'h13, "R4 order slotF");
    endtask

    task automatic t_overwrite();
        int bl;
        log_n = 0;
        load(10'h040);
        for (int i = 0; i < 20; i++) send(8'h30 + 8'(i));
        commit(0, bl);
        check(log_n == 16, "R2 write count", log_n, 16);
        for (int s = 0; s < 16; s++)
            exp_write(s, 10'h040 + 10'(s), (s < 4) ? 8'h40 + 8'(s) : 8'h30 + 8'(s), "R2 overwrite");
    endtask

    task automatic t_wp_upper();
        int bl;
        log_n = 0; wp_i = 1'b1;
        load(10'h230); send(8'h01); send(8'h02); send(8'h03);
        commit(0, bl);
        check(log_n == 0, "R5 upper protected", log_n, 0);
        check(bl == WRC, "R5 busy still runs", bl, WRC);
        wp_i = 1'b0;
    endtask

    task automatic t_wp_lower();
        int bl;
        log_n = 0; wp_i = 1'b1;
        load(10'h1F8); send(8'hC1); send(8'hC2);
        commit(0, bl);
        check(log_n == 2, "R5 lower writable", log_n, 2);
        exp_write(0, 10'h1F8, 8'hC1, "R5 lower");
        exp_write(1, 10'h1F9, 8'hC2, "R5 lower");
        wp_i = 1'b0;
    endtask

    task automatic t_wp_sampled();
        int bl;
        log_n = 0; wp_i = 1'b0;
        load(10'h300); send(8'hD1); send(8'hD2);
        commit(1, bl);
        check(log_n == 2, "R6 late protect ignored", log_n, 2);
        exp_write(0, 10'h300, 8'hD1, "R6 sample");
        exp_write(1, 10'h301, 8'hD2, "R6 sample");
        wp_i = 1'b0;
    endtask

    task automatic t_dummy();
        int bl;
        log_n = 0;
        load(10'h050);
        commit(0, bl);
        repeat (3) @(negedge clk);
        check(bl == 0, "R8 no cycle", bl, 0);
        check(busy == 1'b0, "R8 busy", busy, 0);
        check(log_n == 0, "R8 writes", log_n, 0);
    endtask

    task automatic t_busy_ignore();
        int bl;
        log_n = 0;
        load(10'h080); send(8'h77);
        commit(2, bl);
        check(bl == WRC, "R9 busy length with pokes", bl, WRC);
        check(log_n == 1, "R9 write count", log_n, 1);
        exp_write(0, 10'h080, 8'h77, "R9 data");
        log_n = 0;
        commit(0, bl);
        check(bl == 0, "R9 poked byte not buffered", bl, 0);
        send(8'h66);
        commit(0, bl);
        check(log_n == 1, "R9 follow-up count", log_n, 1);
        exp_write(0, 10'h081, 8'h66, "R9 load ignored");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_wrap();
        t_overwrite();
        t_wp_upper();
        t_wp_lower();
        t_wp_sampled();
        t_dummy();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R7 actual=%0d expected<%0d", cyc, 200000);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule